// File: doc/BRIEF.md
# SPI Register-Access Master

This block turns register requests from a local port into byte frames on an SPI bus, acting as the bus master for a contactless-reader peripheral. A request names a direction, an 8-bit register address, a byte count, a bit-alignment value and a held byte. A write sends one address byte and then `count` data bytes, all to the same register. The data bytes are pulled one at a time from `wr_data`. A read sends the address once and then again for each further byte, and ends with a zero byte. The byte clocked in during the first address byte is dropped. Every later byte comes out on `rd_data` with a one-cycle `rd_valid` strobe.

The bus runs in SPI mode 0: SCLK idles low, MISO is sampled on the rising edge, MOSI changes on the falling edge, and bytes go most significant bit first. One SCLK half-period lasts `HALF_DIV` system clocks. Chip select falls one SCLK period before the first edge and rises one SCLK period after the last edge. A read may merge its first returned byte with the held byte. Bit positions at or above the alignment value take the bus data, and the lower positions keep the held bits.

Top module: `spi_reg_master`

## Requirements
- R1: SPI mode 0: SCLK is low whenever it is not pulsing, MOSI never changes while SCLK is high, and each byte is sent most significant bit first.
- R2: A write request with count N sends N+1 bytes: first `req_addr & 8'h7E` (bit 7 and bit 0 cleared), then N data bytes taken from `wr_data` in order, with one `wr_take` pulse per data byte.
- R3: A read request with count N of at least 1 sends `req_addr | 8'h80` as its first byte, and the byte received during it produces no `rd_valid`.
- R4: A read of N bytes sends the read address byte N times and then `8'h00`, and delivers exactly N bytes on `rd_data`/`rd_valid`, in the order they were received.
- R5: With alignment A (0..7) in a read, bits A..7 of the first delivered byte come from the bus and bits below A come from `req_hold`. A=0 delivers the bus byte unchanged, and all later bytes are never merged.
- R6: `spi_cs_n` falls exactly once per transaction with a nonzero byte total, stays low until after the last byte, and SCLK is low while `spi_cs_n` is high.
- R7: A read request with count 0 produces no chip-select fall, no SCLK edge, no MOSI byte and no `rd_valid`, and still pulses `done`.
- R8: At least 2*HALF_DIV system clocks pass from the fall of chip select to the first SCLK rise, and from the last SCLK fall to the rise of chip select.
- R9: `req_ready` is high only while idle. A request is captured when `req_valid` and `req_ready` are both high. `done` is a one-cycle pulse that comes one cycle after chip select returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_read | input | 1 | 1 = register read, 0 = register write |
| req_addr | input | 8 | Register address |
| req_count | input | CNT_W | Number of data bytes |
| req_align | input | 3 | Bit position from which the first read byte is taken from the bus |
| req_hold | input | 8 | Held byte that supplies bits below the alignment |
| wr_data | input | 8 | Next write data byte, consumed when wr_take is high |
| wr_take | output | 1 | Write data byte consumed at this clock edge |
| rd_data | output | 8 | Received read byte |
| rd_valid | output | 1 | rd_data valid for one cycle |
| done | output | 1 | Transaction finished, one-cycle pulse |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the peripheral |
| spi_miso | input | 1 | Serial data from the peripheral |

## Verification
A behavioural slave in the bench captures the MOSI bytes and returns random MISO bytes. Its results are compared with byte lists built from the requirements. The bench targets these failure modes:
- an off-by-one in the burst count, which would show as an extra or missing address re-send or a missing trailing zero byte;
- a leaked discard byte, which would give one extra `rd_valid`;
- a wrong alignment mask, which would corrupt the low or high bits of the first byte at alignments 3 and 7, or would merge a later byte too;
- a zero-count read that toggles chip select.
A per-clock monitor watches for a MOSI change while SCLK is high, SCLK high while deselected, and chip-select lead or trail times shorter than one SCLK period. It also checks that `done` arrives exactly one cycle after release.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  localparam int BYTE_W  = 8;
  localparam int ALIGN_W = $clog2(BYTE_W);

  localparam logic [BYTE_W-1:0] RD_FLAG  = 8'h80;
  localparam logic [BYTE_W-1:0] WR_MASK  = 8'h7E;
  localparam logic [BYTE_W-1:0] END_BYTE = 8'h00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_XFER,
    ST_TRAIL,
    ST_REL,
    ST_FIN
  } seq_state_e;

  // Build the first byte of a frame from direction and register address.
  function automatic logic [BYTE_W-1:0] frame_addr(input logic is_rd,
                                                   input logic [BYTE_W-1:0] a);
    return is_rd ? (a | RD_FLAG) : (a & WR_MASK);
  endfunction

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign tick   = run && (cnt_q == LAST);
  assign cnt_en = run || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R8

  AST_DIV_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         sample,
  input  logic         shift,
  input  logic         miso,
  output logic         mosi,
  output logic [W-1:0] rx_val,
  output logic         last_bit
);

  localparam int BW = (W > 1) ? $clog2(W) : 1;
  localparam logic [BW-1:0] TOP = BW'(W - 1);

  logic [W-1:0]  tx_q, tx_d;
  logic [W-1:0]  rx_q, rx_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          tx_en;

  assign tx_en    = load || shift;
  assign mosi     = tx_q[W-1];
  assign rx_val   = rx_q;
  assign last_bit = (bit_q == TOP);

  always_comb begin
    tx_d  = tx_q;
    bit_d = bit_q;
    if (load) begin
      tx_d  = load_val;
      bit_d = '0;
    end else if (shift) begin
      tx_d  = {tx_q[W-2:0], 1'b0};
      bit_d = bit_q + 1'b1;
    end
  end

  always_comb begin
    rx_d = {rx_q[W-2:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      bit_q <= '0;
    end else if (tx_en) begin
      tx_q  <= tx_d;
      bit_q <= bit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;
    end else if (sample) begin
      rx_q <= rx_d;
    end
  end

  AST_NO_LOAD_AND_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift)); // R1

  AST_NO_SAMPLE_AND_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample && shift)); // R1

endmodule

// File: rtl/spi_align_merge.sv
module spi_align_merge #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic [W-1:0]  fresh,
  input  logic [W-1:0]  held,
  input  logic [AW-1:0] align,
  output logic [W-1:0]  merged
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic [AW:0] POS = (AW + 1)'(i);
    assign merged[i] = (POS >= {1'b0, align}) ? fresh[i] : held[i];
  end

endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
  import spi_reg_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int CNT_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_read,
  input  logic [7:0]        req_addr,
  input  logic [CNT_W-1:0]  req_count,
  input  logic [2:0]        req_align,
  input  logic [7:0]        req_hold,
  input  logic [7:0]        wr_data,
  output logic              wr_take,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              done,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  seq_state_e          state_q, state_d;
  logic                cs_n_q, cs_n_d;
  logic                sclk_q, sclk_d;
  logic [CNT_W-1:0]    left_q, left_d;
  logic                rd_q, rd_d;
  logic [BYTE_W-1:0]   addr_q, addr_d;
  logic [ALIGN_W-1:0]  align_q, align_d;
  logic [BYTE_W-1:0]   hold_q, hold_d;
  logic                first_q, first_d;
  logic                merge_q, merge_d;
  logic                tail_q, tail_d;
  logic                rdv_q, rdv_d;
  logic [BYTE_W-1:0]   rdd_q, rdd_d;
  logic                accept;

  logic                div_run, tick;
  logic                sh_load, sh_sample, sh_shift;
  logic [BYTE_W-1:0]   sh_byte;
  logic [BYTE_W-1:0]   rx_byte;
  logic [BYTE_W-1:0]   rx_merged;
  logic                last_bit;
  logic                mosi_bit;

  assign div_run = (state_q == ST_LEAD) || (state_q == ST_XFER) ||
                   (state_q == ST_TRAIL);
  assign accept  = req_valid && req_ready;

  spi_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (div_run),
    .tick  (tick)
  );

  spi_byte_shifter #(.W(BYTE_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sh_load),
    .load_val (sh_byte),
    .sample   (sh_sample),
    .shift    (sh_shift),
    .miso     (spi_miso),
    .mosi     (mosi_bit),
    .rx_val   (rx_byte),
    .last_bit (last_bit)
  );

  spi_align_merge #(.W(BYTE_W), .AW(ALIGN_W)) u_merge (
    .fresh  (rx_byte),
    .held   (hold_q),
    .align  (align_q),
    .merged (rx_merged)
  );

  // Next-state logic.
  always_comb begin
    state_d   = state_q;
    cs_n_d    = cs_n_q;
    sclk_d    = sclk_q;
    left_d    = left_q;
    rd_d      = rd_q;
    addr_d    = addr_q;
    align_d   = align_q;
    hold_d    = hold_q;
    first_d   = first_q;
    merge_d   = merge_q;
    tail_d    = tail_q;
    rdv_d     = 1'b0;
    rdd_d     = rdd_q;
    sh_load   = 1'b0;
    sh_sample = 1'b0;
    sh_shift  = 1'b0;
    sh_byte   = '0;
    wr_take   = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          rd_d    = req_read;
          addr_d  = frame_addr(req_read, req_addr);
          align_d = req_align;
          hold_d  = req_hold;
          left_d  = req_count;
          first_d = 1'b1;
          merge_d = 1'b1;
          if (req_read && (req_count == '0)) begin
            state_d = ST_FIN;
          end else begin
            state_d = ST_LEAD;
            cs_n_d  = 1'b0;
            sh_load = 1'b1;
            sh_byte = frame_addr(req_read, req_addr);
          end
        end
      end

      ST_LEAD: begin
        if (tick) begin
          state_d = ST_XFER;
        end
      end

      ST_XFER: begin
        if (tick) begin
          if (!sclk_q) begin
            sclk_d    = 1'b1;
            sh_sample = 1'b1;
          end else begin
            sclk_d = 1'b0;
            if (last_bit) begin
              first_d = 1'b0;
              if (rd_q && !first_q) begin
                rdv_d   = 1'b1;
                rdd_d   = merge_q ? rx_merged : rx_byte;
                merge_d = 1'b0;
              end
              if (left_q == '0) begin
                state_d = ST_TRAIL;
                tail_d  = 1'b0;
              end else begin
                left_d  = left_q - 1'b1;
                sh_load = 1'b1;
                if (rd_q) begin
                  sh_byte = (left_q == ONE) ? END_BYTE : addr_q;
                end else begin
                  sh_byte = wr_data;
                  wr_take = 1'b1;
                end
              end
            end else begin
              sh_shift = 1'b1;
            end
          end
        end
      end

      ST_TRAIL: begin
        if (tick) begin
          if (tail_q) begin
            state_d = ST_REL;
            cs_n_d  = 1'b1;
          end else begin
            tail_d = 1'b1;
          end
        end
      end

      ST_REL: begin
        state_d = ST_FIN;
      end

      ST_FIN: begin
        state_d = ST_IDLE;
      end

      default: begin
        state_d = ST_IDLE;
        cs_n_d  = 1'b1;
        sclk_d  = 1'b0;
      end
    endcase
  end

  // State and output registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
      left_q  <= '0;
      first_q <= 1'b0;
      merge_q <= 1'b0;
      tail_q  <= 1'b0;
      rdv_q   <= 1'b0;
      rdd_q   <= '0;
    end else begin
      state_q <= state_d;
      cs_n_q  <= cs_n_d;
      sclk_q  <= sclk_d;
      left_q  <= left_d;
      first_q <= first_d;
      merge_q <= merge_d;
      tail_q  <= tail_d;
      rdv_q   <= rdv_d;
      rdd_q   <= rdd_d;
    end
  end

  // Request fields, loaded only on acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      addr_q  <= '0;
      align_q <= '0;
      hold_q  <= '0;
    end else if (accept) begin
      rd_q    <= rd_d;
      addr_q  <= addr_d;
      align_q <= align_d;
      hold_q  <= hold_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign done      = (state_q == ST_FIN);
  assign rd_valid  = rdv_q;
  assign rd_data   = rdd_q;
  assign spi_cs_n  = cs_n_q;
  assign spi_sclk  = sclk_q;
  assign spi_mosi  = cs_n_q ? 1'b0 : mosi_bit;

  AST_SCLK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R6

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R1

  AST_DONE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (spi_cs_n && $past(spi_cs_n))); // R9

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (spi_cs_n && !spi_sclk)); // R9

  AST_RDV_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_q); // R3

  AST_TAKE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> !rd_q); // R2

  AST_NO_EDGE_IN_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LEAD) |-> !spi_sclk); // R8

endmodule

// File: tb/spi_reg_master_bench.sv
module spi_reg_master_bench;

  localparam int HALF  = 2;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             req_valid;
  logic             req_ready;
  logic             req_read;
  logic [7:0]       req_addr;
  logic [CNT_W-1:0] req_count;
  logic [2:0]       req_align;
  logic [7:0]       req_hold;
  logic [7:0]       wr_data;
  logic             wr_take;
  logic [7:0]       rd_data;
  logic             rd_valid;
  logic             done;
  logic             spi_cs_n;
  logic             spi_sclk;
  logic             spi_mosi;
  logic             spi_miso = 1'b0;

  always #5 clk = ~clk;

  spi_reg_master #(.HALF_DIV(HALF), .CNT_W(CNT_W)) u_spi_reg_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_read(req_read), .req_addr(req_addr), .req_count(req_count),
    .req_align(req_align), .req_hold(req_hold), .wr_data(wr_data),
    .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid), .done(done),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // Write data source: monotonic index advanced on every consumption.
  logic [7:0] wq [0:511];
  int widx = 0;
  assign wr_data = wq[widx % 512];
  always @(posedge clk) if (rst_n && wr_take) widx <= widx + 1;

  // Behavioural SPI slave (mode 0).
  logic [7:0] s_resp [0:63];
  logic [7:0] mosi_got [0:1023];
  int   mosi_n = 0;
  int   s_byte = 0;
  int   s_bit  = 0;
  logic [7:0] s_rx = 8'h00;
  logic p_cs = 1'b1;
  logic p_sc = 1'b0;

  always @(spi_cs_n or spi_sclk) begin
    if (spi_cs_n === 1'b1) begin
      s_byte   = 0;
      s_bit    = 0;
      spi_miso = 1'b0;
    end else if (spi_cs_n === 1'b0 && p_cs === 1'b1) begin
      s_byte   = 0;
      s_bit    = 0;
      spi_miso = s_resp[0][7];
    end else if (p_sc === 1'b1 && spi_sclk === 1'b0) begin
      s_bit = s_bit + 1;
      if (s_bit == 8) begin
        mosi_got[mosi_n % 1024] = s_rx;
        mosi_n = mosi_n + 1;
        s_bit  = 0;
        s_byte = s_byte + 1;
      end
      spi_miso = s_resp[s_byte % 64][7 - s_bit];
    end else if (p_sc === 1'b0 && spi_sclk === 1'b1) begin
      s_rx = {s_rx[6:0], spi_mosi};
    end
    p_cs = spi_cs_n;
    p_sc = spi_sclk;
  end

  // Per-clock monitor.
  int   cyc = 0;
  int   t_csfall = 0, t_lastfall = 0, t_csrise = 0, t_done = 0;
  int   err_r1 = 0, err_r6 = 0, err_r8 = 0;
  int   cs_falls = 0;
  int   rd_n = 0;
  logic [7:0] got_rd [0:1023];
  logic m_cs = 1'b1, m_sc = 1'b0, m_mo = 1'b0, rise_pend = 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n === 1'b1) begin
      if (spi_cs_n === 1'b0 && m_cs === 1'b1) begin
        t_csfall  = cyc;
        rise_pend = 1'b1;
        cs_falls  = cs_falls + 1;
      end
      if (spi_sclk === 1'b1 && m_sc === 1'b0) begin
        if (rise_pend && (cyc - t_csfall < 2 * HALF)) err_r8 = err_r8 + 1;
        rise_pend = 1'b0;
      end
      if (spi_sclk === 1'b0 && m_sc === 1'b1) t_lastfall = cyc;
      if (spi_cs_n === 1'b1 && m_cs === 1'b0) begin
        t_csrise = cyc;
        if (cyc - t_lastfall < 2 * HALF) err_r8 = err_r8 + 1;
      end
      if (spi_cs_n === 1'b1 && spi_sclk === 1'b1) err_r6 = err_r6 + 1;
      if (spi_sclk === 1'b1 && m_sc === 1'b1 && spi_mosi !== m_mo) err_r1 = err_r1 + 1;
      if (rd_valid === 1'b1) begin
        got_rd[rd_n % 1024] = rd_data;
        rd_n = rd_n + 1;
      end
      if (done === 1'b1) t_done = cyc;
    end
    m_cs = spi_cs_n;
    m_sc = spi_sclk;
    m_mo = spi_mosi;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic run_txn(input bit rd, input logic [7:0] addr, input int cnt,
                         input int al, input logic [7:0] hold);
    logic [7:0] exp_m [0:63];
    logic [7:0] exp_r [0:63];
    int nm, nr, mbase, rbase, wbase, csb, e1, e6, e8, waited, bad, badi;
    string rq_first, rq_rest;
    mbase = mosi_n; rbase = rd_n; wbase = widx; csb = cs_falls;
    e1 = err_r1; e6 = err_r6; e8 = err_r8;
    for (int k = 0; k < 64; k++) s_resp[k] = 8'($urandom);
    if (rd) begin
      for (int k = 0; k < cnt; k++) exp_m[k] = addr | 8'h80;
      exp_m[cnt] = 8'h00;
      nm = (cnt == 0) ? 0 : cnt + 1;
      nr = cnt;
      for (int k = 1; k <= cnt; k++) exp_r[k-1] = s_resp[k];
      if (cnt > 0) begin
        for (int b = 0; b < 8; b++) if (b < al) exp_r[0][b] = hold[b];
      end
      rq_first = "R3"; rq_rest = "R4";
    end else begin
      exp_m[0] = addr & 8'h7E;
      for (int k = 0; k < cnt; k++) begin
        wq[(wbase + k) % 512] = 8'($urandom);
        exp_m[k+1] = wq[(wbase + k) % 512];
      end
      nm = cnt + 1;
      nr = 0;
      rq_first = "R2"; rq_rest = "R2";
    end

    req_read = rd; req_addr = addr; req_count = CNT_W'(cnt);
    req_align = 3'(al); req_hold = hold; req_valid = 1'b1;
    chk(req_ready === 1'b1, "R9", "ready while idle", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready === 1'b0, "R9", "ready while busy", int'(req_ready), 0);
    waited = 0;
    while (done !== 1'b1 && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    chk(done === 1'b1, "R9", "done seen", int'(done), 1);
    @(negedge clk);
    chk(done === 1'b0, "R9", "done one cycle", int'(done), 0);

    if (rd && cnt == 0) begin
      chk(cs_falls == csb, "R7", "chip-select falls", cs_falls - csb, 0);
      chk(mosi_n == mbase, "R7", "bytes on bus", mosi_n - mbase, 0);
      chk(rd_n == rbase, "R7", "read strobes", rd_n - rbase, 0);
    end else begin
      chk(cs_falls == csb + 1, "R6", "chip-select falls", cs_falls - csb, 1);
      chk(t_done == t_csrise + 1, "R9", "done after release", t_done - t_csrise, 1);
      chk(mosi_n - mbase == nm, rq_rest, "MOSI byte count", mosi_n - mbase, nm);
      chk(mosi_got[mbase % 1024] == exp_m[0], rq_first, "first MOSI byte",
          int'(mosi_got[mbase % 1024]), int'(exp_m[0]));
      bad = 0; badi = 1;
      for (int k = 1; k < nm; k++) begin
        if (mosi_got[(mbase + k) % 1024] != exp_m[k] && bad == 0) begin
          bad = 1; badi = k;
        end
      end
      chk(bad == 0, rq_rest, "later MOSI bytes", int'(mosi_got[(mbase + badi) % 1024]),
          int'(exp_m[badi]));
      if (!rd) begin
        chk(widx - wbase == cnt, "R2", "data bytes taken", widx - wbase, cnt);
        chk(rd_n == rbase, "R2", "no read strobe in write", rd_n - rbase, 0);
      end else begin
        chk(rd_n - rbase == nr, "R4", "read byte count", rd_n - rbase, nr);
        chk(got_rd[rbase % 1024] == exp_r[0], (al != 0) ? "R5" : "R4",
            "first read byte", int'(got_rd[rbase % 1024]), int'(exp_r[0]));
        bad = 0; badi = 1;
        for (int k = 1; k < nr; k++) begin
          if (got_rd[(rbase + k) % 1024] != exp_r[k] && bad == 0) begin
            bad = 1; badi = k;
          end
        end
        chk(bad == 0, "R5", "later read bytes unmerged",
            int'(got_rd[(rbase + badi) % 1024]), int'(exp_r[badi]));
      end
    end
    chk(err_r1 == e1, "R1", "MOSI change while SCLK high", err_r1 - e1, 0);
    chk(err_r6 == e6, "R6", "SCLK high while deselected", err_r6 - e6, 0);
    chk(err_r8 == e8, "R8", "lead or trail too short", err_r8 - e8, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: run did not finish, actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_checks + 1, n_fail + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_read = 1'b0; req_addr = '0;
    req_count = '0; req_align = '0; req_hold = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spi_cs_n === 1'b1, "R6", "reset chip select", int'(spi_cs_n), 1);
    chk(spi_sclk === 1'b0, "R1", "reset SCLK", int'(spi_sclk), 0);
    chk(req_ready === 1'b1, "R9", "reset ready", int'(req_ready), 1);
    chk(done === 1'b0 && rd_valid === 1'b0, "R9", "reset strobes",
        int'({done, rd_valid}), 0);

    run_txn(1'b0, 8'h2B, 1, 0, 8'h00);   // single write, R2
    run_txn(1'b0, 8'hFF, 4, 0, 8'h00);   // multi write, address masking R2
    run_txn(1'b0, 8'h13, 0, 0, 8'h00);   // write of address only R2
    run_txn(1'b1, 8'h12, 1, 0, 8'h00);   // single read R3
    run_txn(1'b1, 8'h05, 5, 0, 8'h00);   // burst read R4
    run_txn(1'b1, 8'h7F, 3, 3, 8'hA5);   // aligned merge R5
    run_txn(1'b1, 8'h21, 1, 7, 8'h3C);   // top-bit alignment R5
    run_txn(1'b1, 8'h09, 0, 0, 8'h00);   // zero-count read R7
    run_txn(1'b1, 8'h44, 2, 5, 8'hFF);   // merge with later byte R5
    run_txn(1'b0, 8'h80, 6, 0, 8'h00);   // long write R2

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule